// File: doc/BRIEF.md
# Zoned Waveform Pattern Sequencer

The block replays integer sample patterns from a local sample memory to a converter data port. The memory is carved into numbered zones; each zone is described by a start address and a span (sample count minus one) held in a zone table. A start pulse loads the zone named by the zone select input. Every pulse of the selected step enable then reads one sample and presents it on the output with a valid strobe.

Playback either loops over the active zone indefinitely (continuous mode) or runs through it once and stops with a done pulse (transient mode). While playing, the zone select input may be changed at any time. It is looked at only when the current zone has issued its last sample, so every zone period is emitted whole. The step enable comes from one of two divider pulse inputs, picked by a select bit, or from an external strobe. Changing the pick does not disturb the read pointer, so frequency-shift stimulus stays phase continuous.

A host write port loads the sample memory and the zone table. Zone table writes are accepted at any time. Sample writes are refused while playback is running and raise an error pulse instead.

Top module: `wave_zone_seq`

## Requirements
- R1: After reset sample_out is 0, and sample_valid, play_done, busy and wr_err are all 0.
- R2: A host write with host_tgt=0 stores host_data at sample address host_addr. host_tgt=1 sets the start address of zone host_addr[ZONE_W-1:0]. host_tgt=2 sets that zone's span, which is the number of samples minus one.
- R3: While busy, each selected step pulse causes the next sample of the zone to appear on sample_out, with sample_valid high, in the cycle after the pulse. The first sample is at the zone start. The next samples are at start+1, start+2 and so on, and the address wraps modulo the memory depth.
- R4: In continuous mode (loop_mode=1), the sample after the one at start+span is the zone's start sample again, and busy stays high.
- R5: In transient mode (loop_mode=0), play_done is high for exactly one cycle, together with the valid of the zone's last sample. busy falls in that same cycle, and further step pulses produce no output.
- R6: zone_sel is sampled only at a start pulse and at the step that issues a zone's last sample. A new zone begins with the step right after that last sample.
- R7: With src_ext=0 the step enable is div_a_tick when div_pick=0 and div_b_tick when div_pick=1. With src_ext=1 it is ext_tick. Pulses on the unselected inputs produce no sample.
- R8: Changing div_pick during playback leaves the read position untouched. The next sample after the change follows on from the last one.
- R9: A host sample write (host_tgt=0) while busy leaves the memory unchanged and gives a one-cycle wr_err pulse in the following cycle.
- R10: A play_stop pulse while busy drops busy in the next cycle. No further samples are issued until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_tgt | input | 2 | Write target: 0 sample, 1 zone start, 2 zone span |
| host_addr | input | ADDR_W | Sample address or zone index |
| host_data | input | SAMPLE_W | Write data |
| play_start | input | 1 | Start playback of zone_sel (ignored while busy) |
| play_stop | input | 1 | Abort playback |
| loop_mode | input | 1 | 1 continuous, 0 transient |
| zone_sel | input | ZONE_W | Requested zone |
| src_ext | input | 1 | 1 selects ext_tick as step enable |
| div_pick | input | 1 | Chooses divider B when 1, divider A when 0 |
| div_a_tick | input | 1 | Divider A enable pulse |
| div_b_tick | input | 1 | Divider B enable pulse |
| ext_tick | input | 1 | External strobe pulse |
| sample_out | output | SAMPLE_W | Current sample |
| sample_valid | output | 1 | New sample this cycle |
| play_done | output | 1 | Transient playback complete |
| busy | output | 1 | Playback active |
| wr_err | output | 1 | Refused sample write |

## Verification
The assertions check several properties on every cycle. The done pulse lasts one cycle and coincides with a valid and with busy falling. Valid only follows a busy cycle. An error pulse always traces back to a sample write during playback. A stop always ends playback. The read pointer holds steady whenever no selected step arrived, which covers the phase-continuity guarantee across divider switches. Some behaviours only the scoreboard scenarios can show: the actual sample sequence, the wrap to the zone start, the deferred zone change at the boundary, the address wrap past the top of memory, rejection of unselected enables, and the memory being left unchanged after a refused write.

// File: rtl/zps_pkg.sv
package zps_pkg;
  typedef enum logic [1:0] {
    TGT_SAMPLE = 2'd0,
    TGT_START  = 2'd1,
    TGT_SPAN   = 2'd2
  } host_tgt_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PLAY = 1'b1
  } play_st_e;
endpackage

// File: rtl/zps_tick_mux.sv
module zps_tick_mux (
  input  logic src_ext,
  input  logic div_pick,
  input  logic div_a_tick,
  input  logic div_b_tick,
  input  logic ext_tick,
  output logic tick
);
  logic div_tick;

  always_comb begin
    div_tick = div_pick ? div_b_tick : div_a_tick;
    tick     = src_ext ? ext_tick : div_tick;
  end
endmodule

// File: rtl/zps_zone_table.sv
module zps_zone_table #(
  parameter int ADDR_W = 11,
  parameter int ZONE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_span,
  input  logic [ZONE_W-1:0] wr_zone,
  input  logic [ADDR_W-1:0] wr_val,
  input  logic [ZONE_W-1:0] rd_zone,
  output logic [ADDR_W-1:0] rd_start,
  output logic [ADDR_W-1:0] rd_span
);
  localparam int NZONES = 1 << ZONE_W;

  logic [ADDR_W-1:0] start_q [NZONES];
  logic [ADDR_W-1:0] span_q  [NZONES];

  for (genvar z = 0; z < NZONES; z++) begin : g_zone
    logic hit;
    assign hit = (wr_zone == ZONE_W'(z));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[z] <= '0;
        span_q[z]  <= '0;
      end else begin
        if (wr_start && hit) start_q[z] <= wr_val;
        if (wr_span && hit)  span_q[z]  <= wr_val;
      end
    end
  end

  always_comb begin
    rd_start = start_q[rd_zone];
    rd_span  = span_q[rd_zone];
  end
endmodule

// File: rtl/zps_sample_ram.sv
module zps_sample_ram #(
  parameter int ADDR_W   = 11,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic                re,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [SAMPLE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/zps_play_ctrl.sv
module zps_play_ctrl
  import zps_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_start,
  input  logic              play_stop,
  input  logic              loop_mode,
  input  logic              tick,
  input  logic              samp_wr_req,
  input  logic [ADDR_W-1:0] zone_start,
  input  logic [ADDR_W-1:0] zone_span,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  output logic              samp_wr_ok,
  output logic              valid_q,
  output logic              done_q,
  output logic              err_q,
  output logic              busy
);
  play_st_e          st_q, st_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] span_q, span_n;
  logic [ADDR_W-1:0] off_q, off_n;
  logic              done_n, err_n;
  logic              at_last;

  always_comb begin
    st_n    = st_q;
    base_n  = base_q;
    span_n  = span_q;
    off_n   = off_q;
    done_n  = 1'b0;
    at_last = (off_q == span_q);
    rd_en   = 1'b0;
    busy    = (st_q == ST_PLAY);
    rd_addr = base_q + off_q;
    samp_wr_ok = samp_wr_req && (st_q == ST_IDLE);
    err_n      = samp_wr_req && (st_q == ST_PLAY);

    unique case (st_q)
      ST_IDLE: begin
        if (play_start) begin
          st_n   = ST_PLAY;
          base_n = zone_start;
          span_n = zone_span;
          off_n  = '0;
        end
      end
      ST_PLAY: begin
        if (play_stop) begin
          st_n = ST_IDLE;
        end else if (tick) begin
          rd_en = 1'b1;
          if (at_last) begin
            if (loop_mode) begin
              base_n = zone_start;
              span_n = zone_span;
              off_n  = '0;
            end else begin
              st_n   = ST_IDLE;
              done_n = 1'b1;
            end
          end else begin
            off_n = off_q + ADDR_W'(1);
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      span_q  <= '0;
      off_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      base_q  <= base_n;
      span_q  <= span_n;
      off_q   <= off_n;
      valid_q <= rd_en;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end
endmodule

// File: rtl/wave_zone_seq.sv
module wave_zone_seq
  import zps_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 11,
  parameter int ZONE_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [1:0]          host_tgt,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [SAMPLE_W-1:0] host_data,
  input  logic                play_start,
  input  logic                play_stop,
  input  logic                loop_mode,
  input  logic [ZONE_W-1:0]   zone_sel,
  input  logic                src_ext,
  input  logic                div_pick,
  input  logic                div_a_tick,
  input  logic                div_b_tick,
  input  logic                ext_tick,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                sample_valid,
  output logic                play_done,
  output logic                busy,
  output logic                wr_err
);
  logic              tick_sel;
  logic              samp_wr_req, samp_wr_ok;
  logic              wr_start, wr_span;
  logic [ADDR_W-1:0] z_start, z_span;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_en;

  always_comb begin
    samp_wr_req = host_we && (host_tgt == TGT_SAMPLE);
    wr_start    = host_we && (host_tgt == TGT_START);
    wr_span     = host_we && (host_tgt == TGT_SPAN);
  end

  zps_tick_mux u_tick (
    .src_ext    (src_ext),
    .div_pick   (div_pick),
    .div_a_tick (div_a_tick),
    .div_b_tick (div_b_tick),
    .ext_tick   (ext_tick),
    .tick       (tick_sel)
  );

  zps_zone_table #(.ADDR_W(ADDR_W), .ZONE_W(ZONE_W)) u_zones (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_start (wr_start),
    .wr_span  (wr_span),
    .wr_zone  (host_addr[ZONE_W-1:0]),
    .wr_val   (host_data[ADDR_W-1:0]),
    .rd_zone  (zone_sel),
    .rd_start (z_start),
    .rd_span  (z_span)
  );

  zps_play_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .play_start  (play_start),
    .play_stop   (play_stop),
    .loop_mode   (loop_mode),
    .tick        (tick_sel),
    .samp_wr_req (samp_wr_req),
    .zone_start  (z_start),
    .zone_span   (z_span),
    .rd_addr     (rd_addr),
    .rd_en       (rd_en),
    .samp_wr_ok  (samp_wr_ok),
    .valid_q     (sample_valid),
    .done_q      (play_done),
    .err_q       (wr_err),
    .busy        (busy)
  );

  zps_sample_ram #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (samp_wr_ok),
    .waddr (host_addr),
    .wdata (host_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (sample_out)
  );
endmodule

// File: rtl/wave_zone_seq_chk.sv
module wave_zone_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [1:0]        host_tgt,
  input logic              play_stop,
  input logic              sample_valid,
  input logic              play_done,
  input logic              busy,
  input logic              wr_err,
  input logic              tick_sel,
  input logic [ADDR_W-1:0] rd_addr
);
  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    play_done |=> !play_done);

  // R5: done accompanies the last valid and the end of busy
  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    play_done |-> (sample_valid && !busy));

  // R3: a sample only follows a playing cycle
  p_valid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(busy));

  // R9: error pulse traces back to a refused sample write
  p_wr_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(host_we && (host_tgt == 2'd0) && busy));

  // R8: pointer moves only on a selected step
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick_sel)) |-> $stable(rd_addr));

  // R10: stop ends playback
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(play_stop) && $past(busy)) |-> !busy);
endmodule

bind wave_zone_seq wave_zone_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_we      (host_we),
  .host_tgt     (host_tgt),
  .play_stop    (play_stop),
  .sample_valid (sample_valid),
  .play_done    (play_done),
  .busy         (busy),
  .wr_err       (wr_err),
  .tick_sel     (tick_sel),
  .rd_addr      (rd_addr)
);

// File: tb/wave_zone_seq_tb.sv
module wave_zone_seq_tb;
  localparam int SW    = 16;
  localparam int AW    = 11;
  localparam int ZW    = 7;
  localparam int DEPTH = 1 << AW;

  logic          clk, rst_n;
  logic          host_we;
  logic [1:0]    host_tgt;
  logic [AW-1:0] host_addr;
  logic [SW-1:0] host_data;
  logic          play_start, play_stop, loop_mode;
  logic [ZW-1:0] zone_sel;
  logic          src_ext, div_pick, div_a_tick, div_b_tick, ext_tick;
  logic [SW-1:0] sample_out;
  logic          sample_valid, play_done, busy, wr_err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int tb_mem [DEPTH];
  int tb_start [1 << ZW];
  int tb_span  [1 << ZW];
  bit m_play = 0;
  int m_base, m_span, m_off;

  int exp_q[$];
  bit expd_q[$];

  wave_zone_seq #(.SAMPLE_W(SW), .ADDR_W(AW), .ZONE_W(ZW)) u_dut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops expected samples as the design emits them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (sample_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected sample", int'(sample_out), -1);
        end else begin
          int e; bit d;
          e = exp_q.pop_front();
          d = expd_q.pop_front();
          chk(int'(sample_out) == e, "R3 sample", int'(sample_out), e);
          chk(play_done == d, "R5 done", int'(play_done), int'(d));
        end
      end else if (play_done) begin
        chk(0, "R5 done without valid", 1, 0);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic load_zone();
    m_base = tb_start[zone_sel];
    m_span = tb_span[zone_sel];
    m_off  = 0;
  endtask

  task automatic host_wr(input int tgt, input int addr, input int data);
    host_we = 1; host_tgt = 2'(tgt); host_addr = AW'(addr); host_data = SW'(data);
    if (tgt == 0 && !m_play) tb_mem[addr] = data;
    if (tgt == 1) tb_start[addr % (1 << ZW)] = data % DEPTH;
    if (tgt == 2) tb_span[addr % (1 << ZW)] = data % DEPTH;
    cyc();
    host_we = 0;
  endtask

  task automatic start(input int zone, input bit lp);
    zone_sel = ZW'(zone); loop_mode = lp;
    play_start = 1;
    if (!m_play) begin
      m_play = 1;
      load_zone();
    end
    cyc();
    play_start = 0;
  endtask

  task automatic stop();
    play_stop = 1;
    m_play = 0;
    cyc();
    play_stop = 0;
  endtask

  // which: 0 divider A, 1 divider B, 2 external
  task automatic step(input int which);
    bit sel;
    div_a_tick = (which == 0);
    div_b_tick = (which == 1);
    ext_tick   = (which == 2);
    sel = src_ext ? (which == 2) : (div_pick ? (which == 1) : (which == 0));
    if (sel && m_play) begin
      exp_q.push_back(tb_mem[(m_base + m_off) % DEPTH]);
      if (m_off == m_span) begin
        if (loop_mode) begin
          load_zone();
          expd_q.push_back(0);
        end else begin
          m_play = 0;
          expd_q.push_back(1);
        end
      end else begin
        m_off++;
        expd_q.push_back(0);
      end
    end
    cyc();
    div_a_tick = 0; div_b_tick = 0; ext_tick = 0;
    cyc();
  endtask

  task automatic drain(input string req);
    cyc(); cyc();
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; host_we = 0; host_tgt = 0; host_addr = 0; host_data = 0;
    play_start = 0; play_stop = 0; loop_mode = 1; zone_sel = 0;
    src_ext = 0; div_pick = 0; div_a_tick = 0; div_b_tick = 0; ext_tick = 0;
    foreach (tb_start[i]) begin tb_start[i] = 0; tb_span[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(sample_out == 0 && !sample_valid && !play_done && !busy && !wr_err,
        "R1 reset", {sample_out, 3'b0, sample_valid, play_done, busy, wr_err}, 0);
    rst_n = 1;
    cyc();

    // R2 memory and zone table loading
    for (int i = 0; i < DEPTH; i++) host_wr(0, i, (16'h1000 ^ (i * 37)) & 16'hffff);
    host_wr(1, 0, 10);          host_wr(2, 0, 3);
    host_wr(1, 1, 40);          host_wr(2, 1, 1);
    host_wr(1, 5, DEPTH - 2);   host_wr(2, 5, 3);

    // R3 R4 continuous on divider A, with unselected enables interleaved (R7)
    start(0, 1);
    chk(busy == 1, "R4 busy after start", int'(busy), 1);
    for (int k = 0; k < 6; k++) begin
      step(0);
      step(1);
      step(2);
    end
    drain("R4 continuous drained");

    // R8 switch divider mid-zone
    div_pick = 1;
    step(0);
    for (int k = 0; k < 3; k++) step(1);
    drain("R8 phase continuity");

    // R6 zone change requested mid-zone; current zone finishes first
    zone_sel = 1;
    for (int k = 0; k < 8; k++) step(1);
    drain("R6 zone switch");
    chk(busy == 1, "R4 still busy in loop", int'(busy), 1);

    // R10 stop
    stop();
    chk(busy == 0, "R10 stop", int'(busy), 0);
    step(1);
    drain("R10 no sample after stop");

    // R5 transient on external strobe, across top of memory
    src_ext = 1;
    start(5, 0);
    for (int k = 0; k < 4; k++) step(2);
    @(negedge clk);
    chk(busy == 0, "R5 busy low after transient", int'(busy), 0);
    cyc();
    step(2); step(0);
    drain("R5 no output after done");

    // R9 sample write during play refused
    src_ext = 0; div_pick = 0;
    start(1, 1);
    host_we = 1; host_tgt = 2'd0; host_addr = AW'(40); host_data = 16'hBEEF;
    cyc();
    host_we = 0;
    @(negedge clk);
    chk(wr_err == 1, "R9 wr_err pulse", int'(wr_err), 1);
    cyc();
    chk(wr_err == 0, "R9 wr_err one cycle", int'(wr_err), 0);
    stop();
    start(1, 0);
    step(0); step(0);
    drain("R9 memory unchanged");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule